// File: doc/BRIEF.md
# DMA Channel Transfer Controller

A single DMA channel that moves one data unit per request from a forward-running address pointer to a fixed partner address. Software programs a source pointer, a destination pointer, a reload value for the transfer counter, a cause select and a control word through a small register port. A control bit decides which of the two pointers runs forward. The other pointer stays fixed as the partner address.

Requests come from a selectable cause. The causes are a set of peripheral or external trigger lines and a software trigger. A rising level on the selected cause latches a pending-request bit, whether or not the channel is enabled. When the channel is enabled and idle, the pending request starts a two-phase bus sequence: a read at the forward pointer, then a write of that data to the partner address. Each phase waits for a ready handshake.

In single mode the channel stops on its own once the counter decrements past zero. In repeat mode the counter and the forward pointer reload at that point and the channel keeps running. Every write of 1 to the enable bit puts the channel back in its initial state.

Top module: `dma_chan`

## Requirements
- R1: After reset the enable, mode, direction, pending-request and cause-select fields read zero, the counter and forward pointer read zero, and neither bus strobe is active.
- R2: A rising level on the selected cause sets the pending-request bit (register 4 bit 0) even while the enable bit (register 3 bit 0) is 0. The cause select is register 5: value 0 selects the software trigger and value k selects trig_in[k-1].
- R3: A write to register 4 with bit 0 equal to 0 clears the pending-request bit. A write with bit 0 equal to 1 leaves it unchanged. A write with bit 1 equal to 1 raises the software trigger.
- R4: Changing the cause select from a low line to a line that is already high counts as a rising level and sets the pending-request bit.
- R5: When the channel is enabled, idle and has a pending request, the read phase starts in the next cycle and the pending-request bit is cleared at that start.
- R6: A transfer reads at the forward pointer (register 7), then writes the read data to the partner pointer. Each strobe and its address are held until bus_ready is seen. The forward pointer then advances by one. Register 3 bit 2 equal to 0 makes the source pointer (register 0) run forward and the destination pointer (register 1) the partner; 1 swaps the two roles.
- R7: In single mode (register 3 bit 1 = 0), a reload value N (register 2) gives exactly N+1 transfers. The last transfer decrements the counter (register 6) from zero to all ones and clears the enable bit.
- R8: In repeat mode, the transfer that takes the counter past zero instead reloads the counter from the reload value and the forward pointer from its selected base. The enable bit stays 1.
- R9: Every write to register 3 with bit 0 equal to 1 loads the forward pointer from the selected base pointer and the counter from the reload value, also when the channel is already enabled.
- R10: A request that arrives during a transfer stays pending and is served after that transfer completes.
- R11: Any write to register 3 abandons a transfer in progress. Both strobes drop in the next cycle and neither pointer nor counter advances. After a write of 0 to bit 0, later requests cause no transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | RW | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | RW | Register read data (combinational) |
| trig_in | input | NTRIG | Peripheral and external request lines |
| bus_addr | output | AW | Bus address for the current phase |
| bus_rd | output | 1 | Read phase strobe |
| bus_wr | output | 1 | Write phase strobe |
| bus_wdata | output | DW | Data driven in the write phase |
| bus_rdata | input | DW | Data returned in the read phase |
| bus_ready | input | 1 | Completes the current phase |

## Verification
The bench counts transfers across the zero-crossing of the counter. A design with an off-by-one there would show N or N+2 transfers, or would leave the enable bit set in single mode. In repeat mode it checks the reload. A wrong reload would let the forward pointer run on past its base.

It re-enables an already active channel and checks the reload. A design that ignored that write would keep the old counter and pointer.

It drives requests while the channel is disabled, writes 1 to the pending bit, and switches the cause select onto a line that is already high. Designs that gate latching with the enable bit, let software set the bit, or only detect edges on the line itself would each read back the wrong pending state.

It holds bus_ready low to catch a request arriving mid-transfer and a control write that aborts a transfer. A design that drops the held request, or lets the aborted transfer update the pointers, would be caught by the transfer count or the pointer readback.

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16,
  parameter int NTRIG = 7,
  localparam int RW = (AW > CW) ? AW : CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_waddr,
  input  logic [RW-1:0]    reg_wdata,
  input  logic [2:0]       reg_raddr,
  output logic [RW-1:0]    reg_rdata,
  input  logic [NTRIG-1:0] trig_in,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_ready
);
  localparam int SW = $clog2(NTRIG + 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st_q;

  logic [AW-1:0] src_q, dst_q, fptr_q;
  logic [CW-1:0] rld_q, cnt_q;
  logic [DW-1:0] data_q;
  logic [SW-1:0] sel_q;
  logic en_q, rep_q, fsel_q, req_q, prev_q;

  logic ctl_we, req_we, sw_hit, cause, hit, start, done;
  logic [2**SW-1:0] cv;
  logic [AW-1:0] base, partner;

  assign ctl_we  = reg_we && reg_waddr == 3'd3;
  assign req_we  = reg_we && reg_waddr == 3'd4;
  assign sw_hit  = req_we && reg_wdata[1];
  assign base    = fsel_q ? dst_q : src_q;
  assign partner = fsel_q ? src_q : dst_q;

  always_comb begin
    cv = '0;
    cv[NTRIG:0] = {trig_in, sw_hit};
  end

  assign cause = cv[sel_q];
  assign hit   = cause && !prev_q;
  assign start = st_q == S_IDLE && en_q && req_q && !ctl_we;
  assign done  = st_q == S_WR && bus_ready && !ctl_we;

  assign bus_rd    = st_q == S_RD;
  assign bus_wr    = st_q == S_WR;
  assign bus_addr  = (st_q == S_WR) ? partner : fptr_q;
  assign bus_wdata = data_q;

  always_comb begin
    case (reg_raddr)
      3'd0: reg_rdata = RW'(src_q);
      3'd1: reg_rdata = RW'(dst_q);
      3'd2: reg_rdata = RW'(rld_q);
      3'd3: reg_rdata = RW'({fsel_q, rep_q, en_q});
      3'd4: reg_rdata = RW'(req_q);
      3'd5: reg_rdata = RW'(sel_q);
      3'd6: reg_rdata = RW'(cnt_q);
      default: reg_rdata = RW'(fptr_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      rld_q <= '0;
      sel_q <= '0;
      prev_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      prev_q <= cause;
      if (reg_we && reg_waddr == 3'd0) src_q <= reg_wdata[AW-1:0];
      if (reg_we && reg_waddr == 3'd1) dst_q <= reg_wdata[AW-1:0];
      if (reg_we && reg_waddr == 3'd2) rld_q <= reg_wdata[CW-1:0];
      if (reg_we && reg_waddr == 3'd5) sel_q <= reg_wdata[SW-1:0];
      if (hit) req_q <= 1'b1;
      else if (start) req_q <= 1'b0;
      else if (req_we && !reg_wdata[0]) req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      data_q <= '0;
    end else if (ctl_we) begin
      st_q <= S_IDLE;
    end else begin
      case (st_q)
        S_IDLE: if (start) st_q <= S_RD;
        S_RD: if (bus_ready) begin
          data_q <= bus_rdata;
          st_q <= S_WR;
        end
        default: if (bus_ready) st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      rep_q <= 1'b0;
      fsel_q <= 1'b0;
      fptr_q <= '0;
      cnt_q <= '0;
    end else if (ctl_we) begin
      en_q <= reg_wdata[0];
      rep_q <= reg_wdata[1];
      fsel_q <= reg_wdata[2];
      if (reg_wdata[0]) begin
        fptr_q <= reg_wdata[2] ? dst_q : src_q;
        cnt_q <= rld_q;
      end
    end else if (done) begin
      if (cnt_q == '0 && rep_q) begin
        cnt_q <= rld_q;
        fptr_q <= base;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        fptr_q <= fptr_q + 1'b1;
        if (cnt_q == '0) en_q <= 1'b0;
      end
    end
  end
endmodule

module dma_chan_chk #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_waddr,
  input logic [RW-1:0] reg_wdata,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic          en_q,
  input logic          rep_q,
  input logic          req_q,
  input logic          hit,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] rld_q
);
  logic ctl;
  assign ctl = reg_we && reg_waddr == 3'd3;

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr}));

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && !bus_ready && !reg_we |=>
      $stable(bus_addr) && bus_rd == $past(bus_rd) && bus_wr == $past(bus_wr));

  // R5
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && req_q && !bus_rd && !bus_wr && !ctl |=> bus_rd && (!req_q || $past(hit)));

  // R3
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_waddr == 3'd4 && reg_wdata[0] && !reg_wdata[1] && !req_q && !hit |=> !req_q);

  // R9
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl && reg_wdata[0] |=> en_q && cnt_q == $past(rld_q));

  // R7
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_ready && !ctl && cnt_q == '0 && !rep_q |=> !en_q && cnt_q == '1);

  // R8
  repeat_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_ready && !ctl && cnt_q == '0 && rep_q |=> en_q && cnt_q == $past(rld_q));

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl |=> !bus_rd && !bus_wr);
endmodule

bind dma_chan dma_chan_chk #(.AW(AW), .CW(CW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
  .reg_wdata(reg_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_ready(bus_ready), .bus_addr(bus_addr), .en_q(en_q), .rep_q(rep_q),
  .req_q(req_q), .hit(hit), .cnt_q(cnt_q), .rld_q(rld_q)
);

// File: tb/sim_dma_chan.sv
module sim_dma_chan;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] KEY = 16'h5A3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_waddr = '0, reg_raddr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [6:0] trig_in = '0;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic bus_rd, bus_wr, bus_ready = 1'b0;

  int checks = 0, errs = 0, xfers = 0;
  bit hold = 0, slave_rnd = 0;
  logic [15:0] rd_seen = '0;
  logic [15:0] m_src = 0, m_dst = 0, m_fptr = 0, m_rld = 0, m_cnt = 0;
  bit m_en = 0, m_rep = 0, m_fsel = 0;

  assign bus_rdata = bus_addr ^ KEY;

  dma_chan u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .trig_in(trig_in), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic xfer_done(input logic [15:0] ra, input logic [15:0] wa, input logic [15:0] wd);
    chk("R6 read address", ra, m_fptr);
    chk("R6 write address", wa, m_fsel ? m_src : m_dst);
    chk("R6 data", wd, ra ^ KEY);
    xfers++;
    if (m_cnt == 0 && m_rep) begin
      m_cnt = m_rld;
      m_fptr = m_fsel ? m_dst : m_src;
    end else begin
      if (m_cnt == 0) m_en = 0;
      m_cnt = m_cnt - 1;
      m_fptr = m_fptr + 1;
    end
  endtask

  always @(negedge clk) begin
    if ((bus_rd || bus_wr) && !hold && (!slave_rnd || $urandom % 3 != 0)) bus_ready = 1'b1;
    else bus_ready = 1'b0;
    if (bus_ready && bus_rd) rd_seen = bus_addr;
    if (bus_ready && bus_wr) xfer_done(rd_seen, bus_addr, bus_wdata);
  end

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    case (a)
      3'd0: m_src = d;
      3'd1: m_dst = d;
      3'd2: m_rld = d;
      3'd3: begin
        m_en = d[0]; m_rep = d[1]; m_fsel = d[2];
        if (d[0]) begin m_fptr = d[2] ? m_dst : m_src; m_cnt = m_rld; end
      end
      default: ;
    endcase
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
    reg_raddr = a;
    #1 v = reg_rdata;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); trig_in[i] = 1'b1;
    @(negedge clk); trig_in[i] = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      q = (bus_rd || bus_wr) ? 0 : q + 1;
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int xb;
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd_reg(3, v); chk("R1 control", v, 0);
    rd_reg(4, v); chk("R1 pending", v, 0);
    rd_reg(5, v); chk("R1 select", v, 0);
    rd_reg(6, v); chk("R1 counter", v, 0);
    rd_reg(7, v); chk("R1 pointer", v, 0);
    chk("R1 strobes", {bus_rd, bus_wr}, 0);

    // R9 and R7: single mode, source forward
    wr_reg(0, 16'h0100); wr_reg(1, 16'h0200); wr_reg(2, 3); wr_reg(5, 1);
    wr_reg(3, 16'b001);
    rd_reg(6, v); chk("R9 counter load", v, 3);
    rd_reg(7, v); chk("R9 pointer load", v, 16'h0100);
    xb = xfers;
    for (int i = 0; i < 6; i++) begin pulse(0); wait_idle(); end
    chk("R7 transfer count", xfers - xb, 4);
    rd_reg(3, v); chk("R7 enable cleared", v[0], 0);
    rd_reg(6, v); chk("R7 counter underflow", v, 16'hFFFF);
    rd_reg(7, v); chk("R7 final pointer", v, 16'h0104);

    // R2, R3
    wr_reg(4, 0);
    pulse(0);
    rd_reg(4, v); chk("R2 latched while disabled", v, 1);
    wr_reg(4, 1);
    rd_reg(4, v); chk("R3 write 1 keeps", v, 1);
    wr_reg(4, 0);
    rd_reg(4, v); chk("R3 write 0 clears", v, 0);
    wr_reg(4, 1);
    rd_reg(4, v); chk("R3 write 1 cannot set", v, 0);
    wr_reg(5, 0); wr_reg(4, 16'b10);
    rd_reg(4, v); chk("R3 software trigger", v, 1);
    wr_reg(4, 0);

    // R4
    @(negedge clk); trig_in[2] = 1'b1;
    wr_reg(5, 3);
    @(negedge clk);
    rd_reg(4, v); chk("R4 select switch edge", v, 1);
    trig_in[2] = 1'b0;
    wr_reg(5, 1); wr_reg(4, 0);
    rd_reg(4, v); chk("R4 cleared after", v, 0);

    // R8: repeat mode, destination forward
    wr_reg(0, 16'h0300); wr_reg(1, 16'h0400); wr_reg(2, 1);
    wr_reg(3, 16'b111);
    rd_reg(7, v); chk("R6 destination runs forward", v, 16'h0400);
    xb = xfers;
    for (int i = 0; i < 5; i++) begin pulse(0); wait_idle(); end
    chk("R8 transfer count", xfers - xb, 5);
    rd_reg(3, v); chk("R8 still enabled", v[0], 1);
    rd_reg(6, v); chk("R8 counter", v, m_cnt);
    rd_reg(7, v); chk("R8 pointer", v, m_fptr);

    // R9 restart while active
    wr_reg(3, 16'b111);
    rd_reg(6, v); chk("R9 restart counter", v, 1);
    rd_reg(7, v); chk("R9 restart pointer", v, 16'h0400);

    // R5, R10
    hold = 1;
    xb = xfers;
    pulse(0);
    @(negedge clk);
    chk("R5 read phase started", bus_rd, 1);
    rd_reg(4, v); chk("R5 pending cleared at start", v, 0);
    pulse(0);
    rd_reg(4, v); chk("R10 held during transfer", v, 1);
    hold = 0;
    wait_idle();
    chk("R10 both served", xfers - xb, 2);

    // R11 abort and stop
    hold = 1;
    xb = xfers;
    pulse(0);
    @(negedge clk);
    chk("R11 transfer in flight", bus_rd, 1);
    wr_reg(3, 16'b011);
    chk("R11 strobes dropped", {bus_rd, bus_wr}, 0);
    rd_reg(6, v); chk("R11 counter reloaded", v, m_rld);
    rd_reg(7, v); chk("R11 pointer reloaded", v, 16'h0300);
    hold = 0;
    wr_reg(3, 0);
    pulse(0);
    repeat (4) @(negedge clk);
    chk("R11 no transfer after stop", xfers - xb, 0);
    wr_reg(4, 0);

    // random phase
    slave_rnd = 1;
    for (int c = 0; c < 8; c++) begin
      wait_idle();
      wr_reg(3, 0);
      wr_reg(0, 16'($urandom)); wr_reg(1, 16'($urandom)); wr_reg(2, 16'($urandom % 6));
      wr_reg(3, {13'd0, 1'($urandom), 1'($urandom), 1'b1});
      for (int k = 0; k < 30; k++) begin
        pulse(0);
        repeat ($urandom % 7) @(negedge clk);
      end
      wait_idle();
      rd_reg(6, v); chk("R7 R8 random counter", v, m_cnt);
      rd_reg(7, v); chk("R6 random pointer", v, m_fptr);
      rd_reg(3, v); chk("R7 R8 random enable", v[0], m_en);
    end
    finish_run();
  end
endmodule